// File: doc/BRIEF.md
# Pre-Discharge Bitline Test Controller

This block drives the bitline recovery controls of an SRAM column array on behalf of a memory test engine. Each clock cycle is one access. While the clock is high (the access half), a write access drives the write drivers with the true and complement data. While the clock is low (the recovery half), the bitlines are normally restored high by the precharge circuit.

A single external mode pin selects a stress variant. In that mode the precharge enable stays off for the whole of a selected access cycle. During that cycle's recovery half the existing write drivers are switched on with both rails of every column driven low, so the bitlines are pre-discharged instead of precharged. A weak cell that cannot hold its value against discharged bitlines then shows up in the next read at full speed, without a pause. Two select inputs choose whether the variant follows read cycles, write cycles or both.

The mode pin is synchronised, and the controller samples the synchronised value only at a rising edge. A cycle therefore never mixes the two recovery behaviours. No cycle is ever inserted, so a March sequence runs for the same number of cycles in either mode. With the mode pin low, the outputs are those of a plain precharge controller.

Top module: `pdbl_ctrl`

## Requirements
- R1: While `rst_n` is low, `pre_en` is 1 and `wd_en`, `wd_bl` and `wd_blb` are 0 in both halves, whatever the access and mode inputs.
- R2: `ph_acc` is 1 exactly while `clk` is high and `ph_rec` is 1 exactly while `clk` is low; the two are never both 1.
- R3: A write in a cycle without discharge gives, in the access half, `wd_en`=1, `wd_bl`=data, `wd_blb`=~data and `pre_en`=0; in the recovery half it gives `pre_en`=1 and `wd_en`=0.
- R4: A read in a cycle without discharge gives `pre_en`=0 and `wd_en`=0 in the access half, and `pre_en`=1 and `wd_en`=0 in the recovery half.
- R5: A cycle with no access (`acc_valid`=0 at its starting edge) gives `pre_en`=1 and `wd_en`=0 in both halves.
- R6: A read in stress mode with `rd_disch_sel`=1 holds `pre_en` at 0 in both halves. In the recovery half it gives `wd_en`=1 with `wd_bl` and `wd_blb` all 0.
- R7: A write in stress mode with `wr_disch_sel`=1 keeps the R3 access-half drive, but with `pre_en` at 0. In the recovery half it gives `pre_en`=0 and `wd_en`=1, with `wd_bl` and `wd_blb` all 0.
- R8: In stress mode, a read with `rd_disch_sel`=0 or a write with `wr_disch_sel`=0 behaves exactly as in R4 or R3.
- R9: `test_mode_in` passes through SYNC_STAGES flops (default 2). A value present at rising edge k governs the cycles that start at edge k+SYNC_STAGES-1 and later; the cycle that starts at edge k still uses the old mode.
- R10: An access presented at a rising edge is carried out in the cycle that edge begins, in either mode. Back-to-back accesses take one cycle each.
- R11: `pre_en` and `wd_en` are never both 1.
- R12: Whenever `wd_en` is 0, `wd_bl` and `wd_blb` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Access clock, 50% duty, high half first |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode_in | input | 1 | Asynchronous stress-mode pin |
| rd_disch_sel | input | 1 | Apply discharge after reads in stress mode |
| wr_disch_sel | input | 1 | Apply discharge after writes in stress mode |
| acc_valid | input | 1 | An access starts at this rising edge |
| acc_we | input | 1 | 1 write, 0 read |
| acc_wdata | input | NCOL | Write data, one bit per column |
| ph_acc | output | 1 | Access-half phase |
| ph_rec | output | 1 | Recovery-half phase |
| pre_en | output | 1 | Precharge enable, active high |
| wd_en | output | 1 | Write-driver enable |
| wd_bl | output | NCOL | Drive value for true bitlines |
| wd_blb | output | NCOL | Drive value for complement bitlines |

## Verification
The checker's properties assume that `rst_n` is only released at a falling clock edge. They also assume that the access and select inputs change only while the clock is low, so that each rising edge samples a settled request. The bench drives every input at the falling edge. It samples outputs 2.5 ns into each half, where the combinational phase outputs have settled. Mode changes are made at a falling edge so that the synchroniser latency of R9 can be counted in whole edges.

// File: rtl/pdbl_pkg.sv
`timescale 1ns/1ps
package pdbl_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Turn the request pins into an operation code.
  function automatic op_e f_decode(input logic valid, input logic we);
    if (!valid)  return OP_IDLE;
    else if (we) return OP_WRITE;
    else         return OP_READ;
  endfunction

  // Decide whether this cycle's recovery half discharges instead of precharging.
  function automatic logic f_disch(input logic tm, input op_e op,
                                   input logic rd_sel, input logic wr_sel);
    return tm && (((op == OP_READ) && rd_sel) || ((op == OP_WRITE) && wr_sel));
  endfunction

endpackage

// File: rtl/pdbl_mode_sync.sv
`timescale 1ns/1ps
module pdbl_mode_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= 1'b0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_out = chain[LAST];
endmodule

// File: rtl/pdbl_cycle_reg.sv
`timescale 1ns/1ps
module pdbl_cycle_reg
  import pdbl_pkg::*;
#(
  parameter int NCOL = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic            acc_we,
  input  logic [NCOL-1:0] acc_wdata,
  input  logic            rd_sel,
  input  logic            wr_sel,
  input  logic            tm_sync,
  output op_e             cyc_op,
  output logic [NCOL-1:0] cyc_wdata,
  output logic            cyc_disch
);
  op_e             op_q;
  logic [NCOL-1:0] data_q;
  logic            rd_sel_q;
  logic            wr_sel_q;

  // Everything that shapes a cycle is captured at its starting edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_IDLE;
      data_q   <= '0;
      rd_sel_q <= 1'b0;
      wr_sel_q <= 1'b0;
    end else begin
      op_q     <= f_decode(acc_valid, acc_we);
      data_q   <= acc_wdata;
      rd_sel_q <= rd_sel;
      wr_sel_q <= wr_sel;
    end
  end

  assign cyc_op    = op_q;
  assign cyc_wdata = data_q;
  // tm_sync is itself a flop output and changes only at a rising edge.
  assign cyc_disch = f_disch(tm_sync, op_q, rd_sel_q, wr_sel_q);
endmodule

// File: rtl/pdbl_phase_drv.sv
`timescale 1ns/1ps
module pdbl_phase_drv
  import pdbl_pkg::*;
#(
  parameter int NCOL = 8
) (
  input  logic            clk,
  input  op_e             cyc_op,
  input  logic            cyc_disch,
  input  logic [NCOL-1:0] cyc_wdata,
  output logic            ph_acc,
  output logic            ph_rec,
  output logic            pre_en,
  output logic            wd_en,
  output logic [NCOL-1:0] wd_bl,
  output logic [NCOL-1:0] wd_blb
);
  logic wr_phase;
  logic dis_phase;

  assign ph_acc    = clk;
  assign ph_rec    = ~clk;
  assign wr_phase  = ph_acc && (cyc_op == OP_WRITE);
  assign dis_phase = ph_rec && cyc_disch;
  assign wd_en     = wr_phase || dis_phase;
  assign pre_en    = !cyc_disch && (ph_rec || (cyc_op == OP_IDLE));

  // A discharge leaves both rails at zero, so only write data reaches them.
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign wd_bl[c]  = wr_phase &  cyc_wdata[c];
    assign wd_blb[c] = wr_phase & ~cyc_wdata[c];
  end
endmodule

// File: rtl/pdbl_ctrl.sv
`timescale 1ns/1ps
module pdbl_ctrl
  import pdbl_pkg::*;
#(
  parameter int NCOL        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            test_mode_in,
  input  logic            rd_disch_sel,
  input  logic            wr_disch_sel,
  input  logic            acc_valid,
  input  logic            acc_we,
  input  logic [NCOL-1:0] acc_wdata,
  output logic            ph_acc,
  output logic            ph_rec,
  output logic            pre_en,
  output logic            wd_en,
  output logic [NCOL-1:0] wd_bl,
  output logic [NCOL-1:0] wd_blb
);
  // Internal events brought out by name for the checker.
  logic            tm_sync;
  op_e             cyc_op;
  logic [NCOL-1:0] cyc_wdata;
  logic            cyc_disch;

  pdbl_mode_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (test_mode_in),
    .sync_out (tm_sync)
  );

  pdbl_cycle_reg #(.NCOL(NCOL)) u_cyc (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_we    (acc_we),
    .acc_wdata (acc_wdata),
    .rd_sel    (rd_disch_sel),
    .wr_sel    (wr_disch_sel),
    .tm_sync   (tm_sync),
    .cyc_op    (cyc_op),
    .cyc_wdata (cyc_wdata),
    .cyc_disch (cyc_disch)
  );

  pdbl_phase_drv #(.NCOL(NCOL)) u_drv (
    .clk       (clk),
    .cyc_op    (cyc_op),
    .cyc_disch (cyc_disch),
    .cyc_wdata (cyc_wdata),
    .ph_acc    (ph_acc),
    .ph_rec    (ph_rec),
    .pre_en    (pre_en),
    .wd_en     (wd_en),
    .wd_bl     (wd_bl),
    .wd_blb    (wd_blb)
  );
endmodule

// File: rtl/pdbl_chk.sv
`timescale 1ns/1ps
module pdbl_chk
  import pdbl_pkg::*;
#(
  parameter int NCOL = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic            ph_acc,
  input logic            ph_rec,
  input logic            pre_en,
  input logic            wd_en,
  input logic [NCOL-1:0] wd_bl,
  input logic [NCOL-1:0] wd_blb,
  input op_e             cyc_op,
  input logic            cyc_disch
);
  // At a rising edge the sampled values belong to the recovery half just ended;
  // at a falling edge they belong to the access half just ended.

  AST_PHASE_REC: assert property (@(posedge clk) disable iff (!rst_n)
    ph_rec && !ph_acc); // R2
  AST_PHASE_ACC: assert property (@(negedge clk) disable iff (!rst_n)
    ph_acc && !ph_rec); // R2
  AST_NO_FIGHT_REC: assert property (@(posedge clk) disable iff (!rst_n)
    !(pre_en && wd_en)); // R11
  AST_NO_FIGHT_ACC: assert property (@(negedge clk) disable iff (!rst_n)
    !(pre_en && wd_en)); // R11
  AST_WRITE_DRIVE: assert property (@(negedge clk) disable iff (!rst_n)
    (cyc_op == OP_WRITE) |-> (wd_en && (wd_bl == ~wd_blb) && !pre_en)); // R3
  AST_DISCH_REC: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_disch |-> (wd_en && !pre_en && (wd_bl == '0) && (wd_blb == '0))); // R6
  AST_DISCH_NO_PRE: assert property (@(negedge clk) disable iff (!rst_n)
    cyc_disch |-> !pre_en); // R7
  AST_PLAIN_REC: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_disch |-> (pre_en && !wd_en)); // R4
  AST_IDLE_ACC: assert property (@(negedge clk) disable iff (!rst_n)
    (cyc_op == OP_IDLE) |-> (pre_en && !wd_en)); // R5
  AST_NO_EXTRA_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (cyc_op != OP_IDLE)); // R10
  AST_QUIET_RAILS: assert property (@(negedge clk) disable iff (!rst_n)
    !wd_en |-> ((wd_bl == '0) && (wd_blb == '0))); // R12
endmodule

bind pdbl_ctrl pdbl_chk #(.NCOL(NCOL)) u_pdbl_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .ph_acc    (ph_acc),
  .ph_rec    (ph_rec),
  .pre_en    (pre_en),
  .wd_en     (wd_en),
  .wd_bl     (wd_bl),
  .wd_blb    (wd_blb),
  .cyc_op    (cyc_op),
  .cyc_disch (cyc_disch)
);

// File: tb/test_pdbl_ctrl.sv
`timescale 1ns/1ps
module test_pdbl_ctrl;
  localparam int NCOL = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            test_mode_in = 1'b0;
  logic            rd_disch_sel = 1'b0;
  logic            wr_disch_sel = 1'b0;
  logic            acc_valid = 1'b0;
  logic            acc_we = 1'b0;
  logic [NCOL-1:0] acc_wdata = '0;
  logic            ph_acc, ph_rec, pre_en, wd_en;
  logic [NCOL-1:0] wd_bl, wd_blb;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pdbl_ctrl #(.NCOL(NCOL), .SYNC_STAGES(2)) i_pdbl_ctrl (
    .clk(clk), .rst_n(rst_n), .test_mode_in(test_mode_in),
    .rd_disch_sel(rd_disch_sel), .wr_disch_sel(wr_disch_sel),
    .acc_valid(acc_valid), .acc_we(acc_we), .acc_wdata(acc_wdata),
    .ph_acc(ph_acc), .ph_rec(ph_rec), .pre_en(pre_en), .wd_en(wd_en),
    .wd_bl(wd_bl), .wd_blb(wd_blb)
  );

  // Stimulus with hand-derived enables: exp = {pre_acc, pre_rec, wd_acc, wd_rec}.
  typedef struct packed {
    logic       tm;
    logic       rdv;
    logic       wrv;
    logic       vld;
    logic       we;
    logic [7:0] d;
    logic [3:0] exp;
  } row_t;

  localparam int NROW = 12;
  localparam row_t TBL [NROW] = '{
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA5, 4'b0110},
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 4'b0100},
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF, 4'b1100},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 4'b0001},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, 4'b0011},
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 4'b0100},
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hF0, 4'b0110},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h5A, 4'b1100},
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h0F, 4'b0011},
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 4'b0001},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 4'b0110},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 4'b0100}
  };

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Check one half; rails follow R3/R12: data in a write access half, else zero.
  task automatic half(input string tag, input logic acc_half, input logic e_pre,
                      input logic e_wd, input logic [NCOL-1:0] e_bl,
                      input logic [NCOL-1:0] e_blb);
    chk("R2", "ph_acc", 32'(ph_acc), 32'(acc_half));
    chk("R2", "ph_rec", 32'(ph_rec), 32'(!acc_half));
    chk(tag, "pre_en", 32'(pre_en), 32'(e_pre));
    chk(tag, "wd_en", 32'(wd_en), 32'(e_wd));
    chk(tag, "wd_bl", 32'(wd_bl), 32'(e_bl));
    chk(tag, "wd_blb", 32'(wd_blb), 32'(e_blb));
    chk("R11", "no_fight", 32'(pre_en && wd_en), 32'd0);
  endtask

  function automatic string tag_of(input row_t r);
    logic dis;
    dis = r.tm && r.vld && ((r.we && r.wrv) || (!r.we && r.rdv));
    if (!r.vld)            return "R5";
    else if (dis && !r.we) return "R6";
    else if (dis)          return "R7";
    else if (r.tm)         return "R8";
    else if (r.we)         return "R3";
    else                   return "R4";
  endfunction

  initial begin : watchdog
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    // R1: reset holds a plain precharge state despite active requests.
    test_mode_in = 1'b1; rd_disch_sel = 1'b1; wr_disch_sel = 1'b1;
    acc_valid = 1'b1; acc_we = 1'b1; acc_wdata = 8'hFF;
    @(posedge clk); @(posedge clk); #2.5;
    half("R1", 1'b1, 1'b1, 1'b0, '0, '0);
    @(negedge clk); #2.5;
    half("R1", 1'b0, 1'b1, 1'b0, '0, '0);
    @(negedge clk);
    test_mode_in = 1'b0; acc_valid = 1'b0; rst_n = 1'b1;
    @(negedge clk); @(negedge clk);

    // Table walk: one idle cycle lets the mode settle, then the access.
    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      test_mode_in = TBL[i].tm; rd_disch_sel = TBL[i].rdv;
      wr_disch_sel = TBL[i].wrv; acc_valid = 1'b0;
      @(negedge clk);
      acc_valid = TBL[i].vld; acc_we = TBL[i].we; acc_wdata = TBL[i].d;
      @(posedge clk); #2.5;
      half(tag_of(TBL[i]), 1'b1, TBL[i].exp[3], TBL[i].exp[1],
           TBL[i].exp[1] ? TBL[i].d : '0, TBL[i].exp[1] ? ~TBL[i].d : '0);
      @(negedge clk);
      acc_valid = 1'b0;
      #2.5;
      half(tag_of(TBL[i]), 1'b0, TBL[i].exp[2], TBL[i].exp[0], '0, '0);
    end

    // R9: mode raised just before an access edge is not yet in force.
    @(negedge clk);
    test_mode_in = 1'b0; rd_disch_sel = 1'b1; wr_disch_sel = 1'b1;
    @(negedge clk); @(negedge clk);
    test_mode_in = 1'b1; acc_valid = 1'b1; acc_we = 1'b0;
    @(negedge clk); #2.5;
    half("R9", 1'b0, 1'b1, 1'b0, '0, '0);
    @(negedge clk); #2.5;
    half("R9", 1'b0, 1'b0, 1'b1, '0, '0);
    // Lowering the mode: one more cycle still discharges, then plain.
    @(negedge clk);
    test_mode_in = 1'b0;
    #2.5;
    half("R9", 1'b0, 1'b0, 1'b1, '0, '0);
    @(negedge clk); #2.5;
    half("R9", 1'b0, 1'b0, 1'b1, '0, '0);
    @(negedge clk); #2.5;
    half("R9", 1'b0, 1'b1, 1'b0, '0, '0);

    // R10: back-to-back stressed writes, one cycle each, no gaps.
    @(negedge clk);
    test_mode_in = 1'b1; acc_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      acc_valid = 1'b1; acc_we = 1'b1; acc_wdata = 8'(8'h11 * (k + 1));
      @(posedge clk); #2.5;
      half("R10", 1'b1, 1'b0, 1'b1, 8'(8'h11 * (k + 1)), ~8'(8'h11 * (k + 1)));
      @(negedge clk);
      acc_wdata = 8'h00;
      #2.5;
      half("R10", 1'b0, 1'b0, 1'b1, '0, '0);
    end
    acc_valid = 1'b0;
    // R12 / R5: idle after the burst leaves the rails quiet and precharging.
    @(posedge clk); #2.5;
    half("R12", 1'b1, 1'b1, 1'b0, '0, '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule